// File: doc/BRIEF.md
# System Tick Compare Interrupt Unit

This block sits beside a free-running 63-bit system tick counter and turns two programmable compare points into interrupt events. A supervisor compare register produces a one-cycle match pulse that the surrounding logic uses to set its soft-interrupt request bit 16. A hypervisor compare register, on a match, loads the value 1 into a small hypervisor pending register, whose nonzero contents hold a level interrupt request high until software writes it back to zero.

Each compare register is 64 bits wide. Its low 63 bits are the compare point and its top bit is a disable flag. A compare fires on the single tick on which the counter equals the stored point. It only fires if the point was strictly ahead of the counter at the time of the write, and then only once. Software reaches all three registers through one write port and one combinational read port. A halt input suppresses delivery of the hypervisor match.

Top module: `tick_cmp_irq`

## Requirements
- R1: After reset both compare registers read 0x8000_0000_0000_0000 (disabled), the pending register reads zero, and `sv_pulse` and `hv_irq` are low.
- R2: Select codes: 0 = supervisor compare, 1 = hypervisor compare, 2 = hypervisor pending, 3 = nothing. A write to select 0 or 1 stores all 64 bits, and reading that select returns them. Pending occupies bits [PEND_W-1:0] with zeros above. Reading select 3 returns zero, and a write to select 3 changes nothing.
- R3: A compare write arms a match only when bit 63 is clear and bits [62:0] are strictly greater than `tick_val` in the write cycle. A point equal to or below the counter never fires.
- R4: When an armed supervisor compare equals `tick_val` at a clock edge, `sv_pulse` is high for exactly the following cycle.
- R5: An armed compare fires or is dropped at most once. It stays disarmed after that, even if the counter equals the point again, until the register is rewritten.
- R6: Writing a compare register with bit 63 set cancels any armed match for that register.
- R7: When an armed hypervisor compare equals `tick_val` at an edge and `halted` is low, the pending register becomes 1 after that edge.
- R8: A hypervisor match that occurs while `halted` is high is dropped and disarmed, and the pending register is left unchanged.
- R9: `hv_irq` is high exactly while the pending register is nonzero. Software writes to select 2 load it, so writing zero lowers `hv_irq` on the next cycle.
- R10: A write to a compare register in the same cycle as its match takes precedence, and the old match is not delivered. A hypervisor match delivered in the same cycle as a pending write leaves the pending register at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_val | input | CNT_W | Current system tick counter value |
| halted | input | 1 | Strand halted; blocks hypervisor match delivery |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | CNT_W+1 | Write data |
| rd_sel | input | 2 | Read target select |
| rd_data | output | CNT_W+1 | Read data for `rd_sel` |
| sv_pulse | output | 1 | One-cycle supervisor match pulse |
| hv_irq | output | 1 | Hypervisor interrupt request level |

## Verification
On every cycle, the assertions check several properties. Every supervisor pulse must trace back to an armed equality on the previous edge, and it must leave the compare disarmed. A disabling write must cancel the armed state. A point that is not ahead of the counter must never arm. The hypervisor request must not move while halted unless software writes the pending register, and it may only fall after a zero write. Only the bench scenarios can show that a match fires in the exact cycle, that a second pass of the counter over the same point stays silent, and how same-cycle write and match collisions resolve. The bench compares every cycle against its own register model while the counter advances and occasionally jumps backwards.

// File: rtl/tick_cmp_irq.sv
module tick_cmp_irq #(
  parameter int CNT_W  = 63,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tick_val,
  input  logic             halted,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W:0]   wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W:0]   rd_data,
  output logic             sv_pulse,
  output logic             hv_irq
);
  localparam logic [1:0] SEL_SV   = 2'd0;
  localparam logic [1:0] SEL_HV   = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [CNT_W:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0]  sv_cmp_q, hv_cmp_q;
  logic            sv_armed_q, hv_armed_q, sv_pulse_q;
  logic [PEND_W-1:0] pend_q;

  wire sv_wr   = wr_en && (wr_sel == SEL_SV);
  wire hv_wr   = wr_en && (wr_sel == SEL_HV);
  wire pend_wr = wr_en && (wr_sel == SEL_PEND);
  wire wr_arms = !wr_data[CNT_W] && (wr_data[CNT_W-1:0] > tick_val);
  wire sv_hit  = sv_armed_q && (tick_val == sv_cmp_q[CNT_W-1:0]);
  wire hv_hit  = hv_armed_q && (tick_val == hv_cmp_q[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_cmp_q   <= CMP_RST;
      hv_cmp_q   <= CMP_RST;
      sv_armed_q <= 1'b0;
      hv_armed_q <= 1'b0;
      sv_pulse_q <= 1'b0;
      pend_q     <= '0;
    end else begin
      sv_pulse_q <= sv_hit && !sv_wr;
      if (sv_wr) begin
        sv_cmp_q   <= wr_data;
        sv_armed_q <= wr_arms;
      end else if (sv_hit) begin
        sv_armed_q <= 1'b0;
      end
      if (hv_wr) begin
        hv_cmp_q   <= wr_data;
        hv_armed_q <= wr_arms;
      end else if (hv_hit) begin
        hv_armed_q <= 1'b0;
      end
      if (hv_hit && !hv_wr && !halted)
        pend_q <= PEND_W'(1);
      else if (pend_wr)
        pend_q <= wr_data[PEND_W-1:0];
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_SV:   rd_data = sv_cmp_q;
      SEL_HV:   rd_data = hv_cmp_q;
      SEL_PEND: rd_data = {{(CNT_W+1-PEND_W){1'b0}}, pend_q};
      default:  rd_data = '0;
    endcase
  end

  assign sv_pulse = sv_pulse_q;
  assign hv_irq   = |pend_q;
endmodule

// File: rtl/tick_cmp_irq_chk.sv
module tick_cmp_irq_chk #(
  parameter int CNT_W  = 63,
  parameter int PEND_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tick_val,
  input logic             halted,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W:0]   wr_data,
  input logic             sv_pulse,
  input logic             hv_irq,
  input logic [CNT_W:0]   sv_cmp_q,
  input logic             sv_armed_q
);
  // R4
  sv_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_pulse |-> $past(sv_armed_q && (tick_val == sv_cmp_q[CNT_W-1:0])));

  // R5
  sv_fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_pulse |-> !sv_armed_q);

  // R6
  disable_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[CNT_W]) |=> (!sv_armed_q && !sv_pulse));

  // R3
  no_arm_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !(wr_data[CNT_W-1:0] > tick_val)) |=> !sv_armed_q);

  // R8
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !(wr_en && wr_sel == 2'd2)) |=> $stable(hv_irq));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_irq) |-> $past(wr_en && wr_sel == 2'd2 && wr_data[PEND_W-1:0] == '0));
endmodule

bind tick_cmp_irq tick_cmp_irq_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_val(tick_val), .halted(halted),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sv_pulse(sv_pulse), .hv_irq(hv_irq),
  .sv_cmp_q(sv_cmp_q), .sv_armed_q(sv_armed_q)
);

// File: tb/tick_cmp_irq_tb_top.sv
`timescale 1ns/1ps
module tick_cmp_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [62:0] tick_val;
  logic        halted;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [63:0] wr_data;
  logic [1:0]  rd_sel;
  logic [63:0] rd_data;
  logic        sv_pulse;
  logic        hv_irq;

  int n_checks = 0;
  int n_err    = 0;
  logic [62:0] tick;
  logic [63:0] m_svc, m_hvc;
  logic        m_sva, m_hva, m_pulse;
  logic [3:0]  m_pend;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  tick_cmp_irq #(.CNT_W(63), .PEND_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_val(tick_val), .halted(halted),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .sv_pulse(sv_pulse), .hv_irq(hv_irq)
  );

  function automatic logic [63:0] exp_rd(input logic [1:0] rs);
    case (rs)
      2'd0:    return m_svc;
      2'd1:    return m_hvc;
      2'd2:    return {60'b0, m_pend};
      default: return 64'b0;
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [63:0] d,
                      input logic h, input logic [1:0] rs, input string tag);
    logic sv_hit, hv_hit, arms;
    wr_en = we; wr_sel = sel; wr_data = d; tick_val = tick; halted = h; rd_sel = rs;
    arms   = !d[63] && (d[62:0] > tick);
    sv_hit = m_sva && (tick == m_svc[62:0]);
    hv_hit = m_hva && (tick == m_hvc[62:0]);
    m_pulse = sv_hit && !(we && sel == 2'd0);
    if (we && sel == 2'd0) begin m_svc = d; m_sva = arms; end
    else if (sv_hit) m_sva = 1'b0;
    if (we && sel == 2'd1) begin m_hvc = d; m_hva = arms; end
    else if (hv_hit) m_hva = 1'b0;
    if (hv_hit && !(we && sel == 2'd1) && !h) m_pend = 4'd1;
    else if (we && sel == 2'd2) m_pend = d[3:0];
    @(posedge clk); #1;
    tick = tick + 63'd1;
    check({63'b0, sv_pulse}, {63'b0, m_pulse}, {tag, " sv_pulse (R4)"});
    check({63'b0, hv_irq}, {63'b0, (m_pend != 4'd0)}, {tag, " hv_irq (R9)"});
    check(rd_data, exp_rd(rs), {tag, " rd_data (R2)"});
  endtask

  task automatic idle(input int n, input logic h, input logic [1:0] rs, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 64'd0, h, rs, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [62:0] pt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    tick = 63'd100; tick_val = tick; halted = 1'b0; rd_sel = 2'd0;
    m_svc = {1'b1, 63'b0}; m_hvc = {1'b1, 63'b0};
    m_sva = 1'b0; m_hva = 1'b0; m_pulse = 1'b0; m_pend = 4'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state over every select
    for (int s = 0; s < 4; s++) step(1'b0, 2'(s), 64'd0, 1'b0, 2'(s), "R1");

    // R2 readback and select 3 write ignored
    step(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, "R2");
    step(1'b0, 2'd0, 64'd0, 1'b0, 2'd3, "R2");
    step(1'b0, 2'd0, 64'd0, 1'b0, 2'd1, "R2");

    // R3/R4 supervisor arm and fire three ticks ahead
    step(1'b1, 2'd0, {1'b0, tick + 63'd3}, 1'b0, 2'd0, "R3");
    idle(5, 1'b0, 2'd0, "R4");

    // R5 counter revisits the point: no refire
    tick = m_svc[62:0];
    idle(3, 1'b0, 2'd0, "R5");

    // R3 equal and behind points never arm
    pt = tick;
    step(1'b1, 2'd0, {1'b0, pt}, 1'b0, 2'd0, "R3");
    tick = pt; idle(2, 1'b0, 2'd0, "R3");
    step(1'b1, 2'd0, {1'b0, tick - 63'd2}, 1'b0, 2'd0, "R3");
    tick = m_svc[62:0]; idle(2, 1'b0, 2'd0, "R3");

    // R6 disable bit cancels an armed hypervisor match
    pt = tick + 63'd3;
    step(1'b1, 2'd1, {1'b0, pt}, 1'b0, 2'd1, "R6");
    step(1'b1, 2'd1, {1'b1, pt}, 1'b0, 2'd1, "R6");
    idle(4, 1'b0, 2'd2, "R6");

    // R7 hypervisor match loads pending with 1
    step(1'b1, 2'd1, {1'b0, tick + 63'd2}, 1'b0, 2'd1, "R7");
    idle(4, 1'b0, 2'd2, "R7");

    // R9 software loads and clears pending
    step(1'b1, 2'd2, 64'd0, 1'b0, 2'd2, "R9");
    step(1'b1, 2'd2, 64'h8, 1'b0, 2'd2, "R9");
    step(1'b1, 2'd2, 64'd0, 1'b0, 2'd2, "R9");

    // R8 halted match dropped, then not delivered after unhalt
    pt = tick + 63'd2;
    step(1'b1, 2'd1, {1'b0, pt}, 1'b0, 2'd2, "R8");
    idle(4, 1'b1, 2'd2, "R8");
    tick = pt; idle(2, 1'b0, 2'd2, "R8");

    // R10 compare write on the match cycle wins
    step(1'b1, 2'd0, {1'b0, tick + 63'd1}, 1'b0, 2'd0, "R10");
    step(1'b1, 2'd0, {1'b1, tick}, 1'b0, 2'd0, "R10");
    idle(2, 1'b0, 2'd0, "R10");
    step(1'b1, 2'd1, {1'b0, tick + 63'd1}, 1'b0, 2'd2, "R10");
    step(1'b1, 2'd2, 64'd0, 1'b0, 2'd2, "R10");
    idle(2, 1'b0, 2'd2, "R10");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic we; logic [1:0] sel; logic [63:0] d; logic h;
      if ($urandom_range(0, 9) == 0) tick = tick - 63'($urandom_range(0, 6));
      we  = ($urandom_range(0, 9) < 3);
      sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0)
        d = {($urandom_range(0, 4) == 0), tick + 63'($urandom_range(0, 6))} ;
      else
        d = {$urandom(), $urandom()};
      h = ($urandom_range(0, 4) == 0);
      step(we, sel, d, h, 2'($urandom_range(0, 3)), "RND");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule